// File: doc/BRIEF.md
# Serial byte shifter with latch handshake

This block holds bytes in a small ring buffer and sends them, one at a time, to an external serial-in/parallel-out shift register over two wires: a data line and a shift clock. Once all bits of a byte have been clocked out, it pulses a reset line into an external set/reset latch. That latch's output tells a downstream reader that a fresh byte is sitting in the shift register.

Flow control comes from the same latch. The reader sets the latch once it has taken the previous byte. The block starts a new byte only when the latch output is high and the buffer holds data. While a byte is being shifted, the block raises a suspend output. This lets a neighbouring serial receiver that shares the data pin pause its sampling for the duration.

Top module: `sbs_byte_shifter`

## Requirements
- R1: While reset is held, `ser_clk` is high, `ser_data`, `latch_rst`, `busy`, `rx_suspend` and `fifo_full` are low, and `fifo_empty` is high.
- R2: With the buffer empty, meaning its read and write positions are equal, the block stays idle with no shift-clock edges.
- R3: While `latch_ok` is low, no transfer starts and any buffered byte stays queued. A transfer starts once `latch_ok` is sampled high.
- R4: Each byte goes out as `DATA_W` bits, most significant first. `ser_data` is set while `ser_clk` is low and is stable across the rising edge of `ser_clk`, which is the capture edge. `ser_clk` idles high.
- R5: Every low phase and every high phase of `ser_clk` lasts exactly `PHASE_CYC` clock cycles.
- R6: After the last rising edge of a byte, `latch_rst` goes high for exactly `PHASE_CYC` cycles and then low. This happens once per byte, with `ser_clk` held high throughout.
- R7: `busy` and `rx_suspend` are high from the first cycle of a transfer until the pulse on `latch_rst` ends. They are low in the cycle in which `latch_rst` has returned low.
- R8: Bytes leave in the order they were accepted. Both buffer positions wrap to the start after the last slot, so streams longer than `DEPTH` keep their order.
- R9: The buffer holds at most `DEPTH-1` bytes, and `fifo_full` is high at that occupancy. A `push` sampled while `fifo_full` is high is dropped.
- R10: The buffer is read exactly once per transfer, in its first cycle, so every accepted byte is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write one byte into the buffer |
| push_data | input | DATA_W | Byte to write |
| fifo_full | output | 1 | Buffer holds DEPTH-1 bytes |
| fifo_empty | output | 1 | Buffer holds no byte |
| latch_ok | input | 1 | External latch output; high when the reader has taken the last byte |
| ser_data | output | 1 | Serial data to the external shift register |
| ser_clk | output | 1 | Shift clock, capture on rising edge, idles high |
| latch_rst | output | 1 | Reset pulse to the external latch |
| busy | output | 1 | A transfer is in progress |
| rx_suspend | output | 1 | Hold request for a receiver sharing the data pin |

## Verification
The assertions take for granted that `latch_ok` behaves like a real set/reset latch output: it falls only because of the pulse on `latch_rst` and rises only when the reader acknowledges. They also assume `push` is a synchronous single-cycle strobe. The bench meets these assumptions by modelling the latch as a register. The pulse clears that register, and a bench task or an auto-acknowledge mode sets it again. Stimulus changes only on falling clock edges.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_LOW   = 2'd1,
      SH_HIGH  = 2'd2,
      SH_PULSE = 2'd3
   } sh_state_t;
endpackage

// File: rtl/sbs_ring_fifo.sv
module sbs_ring_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int  AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sbs_ring_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sbs_ring_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic          wr_ok, rd_ok;

   // Position advance: natural wrap for powers of two, explicit compare otherwise.
   generate
      if (POW2) begin : g_wrap_pow2
         assign wp_nxt = wp + AW'(1);
         assign rp_nxt = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_nxt = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nxt = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   assign empty   = (wp == rp);
   assign full    = (wp_nxt == rp);
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_ok) wp <= wp_nxt;
         if (rd_ok) rp <= rp_nxt;
      end
   end
endmodule

// File: rtl/sbs_phase_timer.sv
module sbs_phase_timer #(
   parameter int PHASE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("sbs_phase_timer: PHASE_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = (cnt == CW'(PHASE_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/sbs_shift_ctrl.sv
module sbs_shift_ctrl
   import sbs_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         avail,
   input  logic         latch_ok,
   input  logic [W-1:0] load_data,
   input  logic         phase_done,
   output logic         take,
   output logic         phase_clr,
   output logic         busy,
   output logic         sclk,
   output logic         sdata,
   output logic         lreset
);
   localparam int BW = (W > 2) ? $clog2(W) : 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("sbs_shift_ctrl: W must be at least 2");
      end
   endgenerate

   sh_state_t     state;
   logic [W-1:0]  shreg;
   logic [BW-1:0] bit_idx;
   logic          start;

   assign start     = (state == SH_IDLE) && avail && latch_ok;
   assign take      = start;
   assign phase_clr = (state == SH_IDLE) || phase_done;
   assign busy      = (state != SH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SH_IDLE;
         shreg   <= '0;
         bit_idx <= '0;
         sclk    <= 1'b1;
         sdata   <= 1'b0;
         lreset  <= 1'b0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (start) begin
                  shreg   <= load_data;
                  bit_idx <= '0;
                  sdata   <= load_data[W-1];
                  sclk    <= 1'b0;
                  state   <= SH_LOW;
               end
            end
            SH_LOW: begin
               if (phase_done) begin
                  sclk  <= 1'b1;
                  state <= SH_HIGH;
               end
            end
            SH_HIGH: begin
               if (phase_done) begin
                  if (bit_idx == BW'(W - 1)) begin
                     lreset <= 1'b1;
                     state  <= SH_PULSE;
                  end else begin
                     bit_idx <= bit_idx + BW'(1);
                     shreg   <= shreg << 1;
                     sdata   <= shreg[W-2];
                     sclk    <= 1'b0;
                     state   <= SH_LOW;
                  end
               end
            end
            SH_PULSE: begin
               if (phase_done) begin
                  lreset <= 1'b0;
                  sdata  <= 1'b0;
                  state  <= SH_IDLE;
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sbs_byte_shifter.sv
module sbs_byte_shifter #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 8,
   parameter int PHASE_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   output logic              fifo_full,
   output logic              fifo_empty,
   input  logic              latch_ok,
   output logic              ser_data,
   output logic              ser_clk,
   output logic              latch_rst,
   output logic              busy,
   output logic              rx_suspend
);
   logic [DATA_W-1:0] head;
   logic              take, phase_clr, phase_done;

   sbs_ring_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_data (push_data),
      .rd_en   (take),
      .rd_data (head),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   sbs_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .done  (phase_done)
   );

   sbs_shift_ctrl #(.W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .avail      (!fifo_empty),
      .latch_ok   (latch_ok),
      .load_data  (head),
      .phase_done (phase_done),
      .take       (take),
      .phase_clr  (phase_clr),
      .busy       (busy),
      .sclk       (ser_clk),
      .sdata      (ser_data),
      .lreset     (latch_rst)
   );

   assign rx_suspend = busy;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
   input logic clk,
   input logic rst_n,
   input logic fifo_full,
   input logic fifo_empty,
   input logic latch_ok,
   input logic ser_data,
   input logic ser_clk,
   input logic latch_rst,
   input logic busy
);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ser_clk && !latch_rst));

   // R4
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> $stable(ser_data));

   // R6
   pulse_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_rst |-> (ser_clk && busy));

   // R3
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(latch_ok) && !$past(fifo_empty)));

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && busy) |=> fifo_full);
endmodule

bind sbs_byte_shifter sbs_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .latch_ok   (latch_ok),
   .ser_data   (ser_data),
   .ser_clk    (ser_clk),
   .latch_rst  (latch_rst),
   .busy       (busy)
);

// File: tb/sbs_byte_shifter_tb.sv
module sbs_byte_shifter_tb;
   localparam int DW = 8;
   localparam int DP = 8;
   localparam int PC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic          fifo_full, fifo_empty, ser_data, ser_clk, latch_rst, busy, rx_suspend;
   logic          lq, ack_pulse = 1'b0, auto_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_q [256];
   logic [DW-1:0] rcv   [256];
   int exp_n = 0;
   int rcv_n = 0;
   int rise_total = 0;

   logic          prev_sclk = 1'b1, prev_lr = 1'b0, have_rise = 1'b0;
   int            low_cnt = 0, high_cnt = 0, pulse_cnt = 0, bit_cnt = 0;
   logic [DW-1:0] acc = '0;

   always #4 clk = ~clk;

   sbs_byte_shifter #(.DATA_W(DW), .DEPTH(DP), .PHASE_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .latch_ok(lq),
      .ser_data(ser_data), .ser_clk(ser_clk), .latch_rst(latch_rst),
      .busy(busy), .rx_suspend(rx_suspend)
   );

   // External set/reset latch model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            lq <= 1'b1;
      else if (latch_rst)                    lq <= 1'b0;
      else if (ack_pulse || (auto_ack && !lq)) lq <= 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // External shift register model and phase timing monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && !prev_sclk) begin
            chk(low_cnt == PC, "R5 low phase", low_cnt, PC);
            acc = {acc[DW-2:0], ser_data};
            bit_cnt++;
            rise_total++;
            low_cnt = 0;
            high_cnt = 1;
            have_rise = 1'b1;
         end else if (!ser_clk) begin
            if (prev_sclk && have_rise) chk(high_cnt == PC, "R5 high phase", high_cnt, PC);
            low_cnt++;
            chk(busy && rx_suspend, "R7 busy while low", busy, 1);
         end else if (!latch_rst) begin
            high_cnt++;
         end
         if (latch_rst && !prev_lr) begin
            chk(high_cnt == PC, "R5 last high phase", high_cnt, PC);
            chk(bit_cnt == DW, "R6 pulse after last bit", bit_cnt, DW);
            have_rise = 1'b0;
            pulse_cnt = 1;
         end else if (latch_rst) begin
            pulse_cnt++;
         end
         if (latch_rst) chk(ser_clk && busy, "R6 clk high in pulse", ser_clk, 1);
         if (!latch_rst && prev_lr) begin
            chk(pulse_cnt == PC, "R6 pulse width", pulse_cnt, PC);
            chk(!busy && !rx_suspend, "R7 busy drops after pulse", busy, 0);
            rcv[rcv_n] = acc;
            rcv_n++;
            bit_cnt = 0;
            low_cnt = 0;
         end
         prev_sclk = ser_clk;
         prev_lr   = latch_rst;
      end
   end

   task automatic push_byte(input logic [DW-1:0] b);
      @(negedge clk);
      if (!fifo_full) begin
         exp_q[exp_n] = b;
         exp_n++;
      end
      push = 1'b1;
      push_data = b;
      @(negedge clk);
      push = 1'b0;
   endtask

   task automatic wait_rcv(input int n);
      for (int i = 0; i < 3000 && rcv_n < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(ser_clk == 1'b1, "R1 ser_clk", ser_clk, 1);
      chk(ser_data == 1'b0, "R1 ser_data", ser_data, 0);
      chk(latch_rst == 1'b0, "R1 latch_rst", latch_rst, 0);
      chk(!busy && !rx_suspend, "R1 busy", busy, 0);
      chk(fifo_empty && !fifo_full, "R1 flags", {fifo_empty, fifo_full}, 2);
      rst_n = 1'b1;
   endtask

   task automatic t_idle_empty;
      repeat (40) @(negedge clk);
      chk(rise_total == 0, "R2 no clock edges", rise_total, 0);
      chk(!busy && ser_clk, "R2 idle", busy, 0);
   endtask

   task automatic t_single;
      push_byte(8'hA5);
      wait_rcv(1);
      chk(rcv_n == 1, "R10 one byte", rcv_n, 1);
      chk(rcv[0] == 8'hA5, "R4 msb first", rcv[0], 8'hA5);
      chk(fifo_empty, "R10 buffer drained", fifo_empty, 1);
   endtask

   task automatic t_latch_hold;
      push_byte(8'h3C);
      repeat (60) @(negedge clk);
      chk(rcv_n == 1 && !busy && ser_clk, "R3 held while latch low", rcv_n, 1);
      chk(!fifo_empty, "R3 byte stays queued", fifo_empty, 0);
      @(negedge clk); ack_pulse = 1'b1;
      @(negedge clk); ack_pulse = 1'b0;
      wait_rcv(2);
      chk(rcv_n == 2 && rcv[1] == 8'h3C, "R3 sent after latch set", rcv[1], 8'h3C);
   endtask

   task automatic t_full;
      for (int i = 0; i < DP + 2; i++) push_byte(DW'(8'h10 + i));
      chk(fifo_full, "R9 full at DEPTH-1", fifo_full, 1);
      chk(exp_n == 2 + DP - 1, "R9 accepted count", exp_n, 2 + DP - 1);
      auto_ack = 1'b1;
      wait_rcv(exp_n);
      repeat (80) @(negedge clk);
      chk(rcv_n == exp_n, "R9 extras dropped", rcv_n, exp_n);
   endtask

   task automatic t_stream;
      for (int i = 0; i < 20; i++) begin
         push_byte(DW'(i * 37 + 5));
         repeat (20) @(negedge clk);
      end
      wait_rcv(exp_n);
      repeat (80) @(negedge clk);
      chk(rcv_n == exp_n, "R10 each byte once", rcv_n, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(rcv[i] == exp_q[i], "R8 order across wrap", rcv[i], exp_q[i]);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_idle_empty();
      t_single();
      t_latch_hold();
      t_full();
      t_stream();
      finish_run();
   end
endmodule